// File: doc/BRIEF.md
# Video Line Standard Detector

The detector watches the horizontal and vertical sync strobes of a video source and decides whether the source carries 625 or 525 lines per frame. It counts the horizontal strobes that fall between two accepted vertical strobes. A count inside the 625-line window or the 525-line window becomes a new decision only when two fields in a row give the same class. A count outside both windows leaves the reported standard as it was. Downstream logic, such as the decimation window and the frame-mode gate, reads the reported standard, a valid flag, the field identity and a cleaned vertical strobe.

Before the vertical strobe is used, it is delayed by a programmable number of fixed steps. The delay moves its phase against the horizontal strobe. The field identity comes from that phase: a delayed vertical strobe late in a line marks the odd field. A noise filter can be switched on. It drops any vertical strobe that comes too few lines after the last accepted one. A two-bit mode lets the system force either standard or freeze the value currently reported. Automatic detection keeps running underneath in every mode.

Top module: `line_std_detector`

## Requirements
- R1: After reset, `std_is_625`, `std_valid`, `field_odd` and `vsync_clean` are all 0.
- R2: In mode 00, a new standard is reported, and `std_valid` is set, only when two consecutive measured fields fall in the same window. A single field of the other class changes nothing.
- R3: A field of LO_625..HI_625 lines (default 310..315) classifies as 625 lines and sets `std_is_625`=1. A field of LO_525..HI_525 lines (default 260..265) classifies as 525 lines and sets `std_is_625`=0.
- R4: A field count outside both windows leaves `std_is_625` and `std_valid` unchanged.
- R5: Mode 01 reports 625 lines and mode 10 reports 525 lines. In both, `std_valid`=1 one clock after the mode is applied, whatever the input.
- R6: Mode 11 holds `std_is_625` and `std_valid` at their values. Detection continues underneath, so a return to mode 00 shows the latest automatic decision one clock later.
- R7: The vertical strobe is delayed by `vs_delay`×STEP_CYCLES clocks. The matching `vsync_clean` pulse appears `vs_delay`×STEP_CYCLES+2 clocks after the cycle in which `vsync_pulse` is high. A new strobe during a pending delay restarts the delay.
- R8: With `vs_nr_en`=1, a delayed vertical strobe that arrives after fewer than MIN_LINES horizontal strobes since the last accepted one is dropped. It produces no `vsync_clean` pulse and does not split the line count. With `vs_nr_en`=0, every delayed strobe is accepted.
- R9: On each accepted vertical strobe, `field_odd` is set to 1 if at least HALF_LINE clocks have passed since the last horizontal strobe at the delayed strobe's arrival, and to 0 otherwise. It does not change between accepted strobes.
- R10: The first accepted vertical strobe after reset only opens the count. It does not classify, so at least three accepted strobes are needed before `std_valid` rises in mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_pulse | input | 1 | One-clock horizontal sync strobe |
| vsync_pulse | input | 1 | One-clock raw vertical sync strobe |
| mode | input | 2 | 00 auto, 01 force 625, 10 force 525, 11 hold |
| vs_nr_en | input | 1 | Enables the vertical noise filter |
| vs_delay | input | 5 | Vertical strobe delay in steps of STEP_CYCLES clocks |
| std_is_625 | output | 1 | 1 = 625-line, 0 = 525-line |
| std_valid | output | 1 | Reported standard is meaningful |
| field_odd | output | 1 | Field identity from the vertical-to-horizontal phase |
| vsync_clean | output | 1 | One-clock accepted, delayed vertical strobe |

## Verification
The bench feeds whole fields of chosen line counts and checks the decisions that a premature or missing agreement rule would get wrong. A detector that acts on one field would flip after the first 262-line field. A detector that ignores the reference rule would report valid one field too early. A glitch strobe twenty lines into a field is used twice. With the filter on, a design that accepted it would split the count into 20 and 292 and never lock 625. With the filter off, a design that still dropped it would show one clean pulse instead of two. The strobe latency and the field bit are measured with the delay at zero and at a non-zero value, and mode 11 is checked across fields that would otherwise change the answer.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_625  = 2'b01,
        CLS_525  = 2'b10
    } std_cls_e;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'b00,
        MODE_F625  = 2'b01,
        MODE_F525  = 2'b10,
        MODE_HOLD  = 2'b11
    } det_mode_e;

endpackage

// File: rtl/lsd_vs_delay.sv
module lsd_vs_delay #(
    parameter int DEL_W       = 5,
    parameter int STEP_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_in,
    input  logic [DEL_W-1:0] vs_delay,
    output logic             vs_out
);
    localparam int MAX_DLY = ((1 << DEL_W) - 1) * STEP_CYCLES;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_CYCLES);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (vs_in) begin
            if (vs_delay == '0) begin
                st_d.pulse = 1'b1;
                st_d.pend  = 1'b0;
            end else begin
                st_d.pend = 1'b1;
                st_d.cnt  = CNT_W'(vs_delay) * STEP_C - 1'b1;
            end
        end else if (st_q.pend) begin
            if (st_q.cnt == '0) begin
                st_d.pulse = 1'b1;
                st_d.pend  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vs_out = st_q.pulse;

    a_r7_zero_delay_next: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_in && vs_delay == '0) |=> vs_out);

    a_r7_no_pulse_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_in && !st_q.pend) |=> !vs_out);

endmodule

// File: rtl/lsd_vs_filter.sv
module lsd_vs_filter #(
    parameter int LINE_W    = 10,
    parameter int PH_W      = 11,
    parameter int MIN_LINES = 200,
    parameter int HALF_LINE = 432
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_in,
    input  logic              vs_dly,
    input  logic              nr_en,
    output logic              ev_valid,
    output logic              ev_has_ref,
    output logic [LINE_W-1:0] ev_lines,
    output logic              field_odd
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [PH_W-1:0]   PH_MAX   = '1;
    localparam logic [LINE_W-1:0] MIN_L    = LINE_W'(MIN_LINES);
    localparam logic [PH_W-1:0]   HALF_C   = PH_W'(HALF_LINE);

    typedef struct packed {
        logic [LINE_W-1:0] lines;
        logic [PH_W-1:0]   phase;
        logic              ref_seen;
        logic              ev;
        logic              ev_ref;
        logic [LINE_W-1:0] ev_cnt;
        logic              field;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d    = st_q;
        st_d.ev = 1'b0;

        if (hs_in) begin
            st_d.phase = '0;
            if (st_q.lines != LINE_MAX) st_d.lines = st_q.lines + 1'b1;
        end else if (st_q.phase != PH_MAX) begin
            st_d.phase = st_q.phase + 1'b1;
        end

        accept = vs_dly && (!st_q.ref_seen || !nr_en || (st_q.lines >= MIN_L));

        if (accept) begin
            st_d.ev       = 1'b1;
            st_d.ev_ref   = st_q.ref_seen;
            st_d.ev_cnt   = st_q.lines;
            st_d.ref_seen = 1'b1;
            st_d.field    = (st_q.phase >= HALF_C);
            st_d.lines    = hs_in ? LINE_W'(1) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ev_valid   = st_q.ev;
    assign ev_has_ref = st_q.ev_ref;
    assign ev_lines   = st_q.ev_cnt;
    assign field_odd  = st_q.field;

    a_r9_field_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!vs_dly) |=> $stable(field_odd));

    a_r8_event_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(vs_dly));

    a_r8_raw_passes_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_dly && !nr_en) |=> ev_valid);

endmodule

// File: rtl/lsd_classifier.sv
module lsd_classifier
    import lsd_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int LO_625 = 310,
    parameter int HI_625 = 315,
    parameter int LO_525 = 260,
    parameter int HI_525 = 265
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_has_ref,
    input  logic [LINE_W-1:0] ev_lines,
    output logic              auto_625,
    output logic              auto_valid
);
    typedef struct packed {
        std_cls_e prev;
        logic     is_625;
        logic     valid;
    } cls_st_t;

    cls_st_t  st_d, st_q;
    std_cls_e cls;

    always_comb begin
        st_d = st_q;
        if (ev_lines >= LINE_W'(LO_625) && ev_lines <= LINE_W'(HI_625))
            cls = CLS_625;
        else if (ev_lines >= LINE_W'(LO_525) && ev_lines <= LINE_W'(HI_525))
            cls = CLS_525;
        else
            cls = CLS_NONE;

        if (ev_valid && ev_has_ref) begin
            if (cls != CLS_NONE && cls == st_q.prev) begin
                st_d.is_625 = (cls == CLS_625);
                st_d.valid  = 1'b1;
            end
            st_d.prev = cls;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: CLS_NONE, is_625: 1'b0, valid: 1'b0};
        else        st_q <= st_d;
    end

    assign auto_625   = st_q.is_625;
    assign auto_valid = st_q.valid;

    a_r4_change_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid) |=> ($stable(auto_625) && $stable(auto_valid)));

    a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        auto_valid |=> auto_valid);

    a_r10_no_decision_without_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_has_ref) |=> ($stable(auto_625) && $stable(auto_valid)));

endmodule

// File: rtl/line_std_detector.sv
module line_std_detector
    import lsd_pkg::*;
#(
    parameter int DEL_W         = 5,
    parameter int STEP_CYCLES   = 32,
    parameter int MAX_LINES     = 1023,
    parameter int MAX_LINE_CLKS = 2047,
    parameter int HALF_LINE     = 432,
    parameter int MIN_LINES     = 200,
    parameter int LO_625        = 310,
    parameter int HI_625        = 315,
    parameter int LO_525        = 260,
    parameter int HI_525        = 265
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_pulse,
    input  logic             vsync_pulse,
    input  logic [1:0]       mode,
    input  logic             vs_nr_en,
    input  logic [DEL_W-1:0] vs_delay,
    output logic             std_is_625,
    output logic             std_valid,
    output logic             field_odd,
    output logic             vsync_clean
);
    localparam int LINE_W = $clog2(MAX_LINES + 1);
    localparam int PH_W   = $clog2(MAX_LINE_CLKS + 1);

    typedef struct packed {
        logic is_625;
        logic valid;
    } out_st_t;

    logic              vs_dly;
    logic              ev_valid, ev_has_ref;
    logic [LINE_W-1:0] ev_lines;
    logic              auto_625, auto_valid;
    out_st_t           out_d, out_q;

    lsd_vs_delay #(
        .DEL_W       (DEL_W),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .vs_in    (vsync_pulse),
        .vs_delay (vs_delay),
        .vs_out   (vs_dly)
    );

    lsd_vs_filter #(
        .LINE_W    (LINE_W),
        .PH_W      (PH_W),
        .MIN_LINES (MIN_LINES),
        .HALF_LINE (HALF_LINE)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_in      (hsync_pulse),
        .vs_dly     (vs_dly),
        .nr_en      (vs_nr_en),
        .ev_valid   (ev_valid),
        .ev_has_ref (ev_has_ref),
        .ev_lines   (ev_lines),
        .field_odd  (field_odd)
    );

    lsd_classifier #(
        .LINE_W (LINE_W),
        .LO_625 (LO_625),
        .HI_625 (HI_625),
        .LO_525 (LO_525),
        .HI_525 (HI_525)
    ) u_class (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_has_ref (ev_has_ref),
        .ev_lines   (ev_lines),
        .auto_625   (auto_625),
        .auto_valid (auto_valid)
    );

    always_comb begin
        out_d = out_q;
        case (det_mode_e'(mode))
            MODE_AUTO: out_d = '{is_625: auto_625, valid: auto_valid};
            MODE_F625: out_d = '{is_625: 1'b1,     valid: 1'b1};
            MODE_F525: out_d = '{is_625: 1'b0,     valid: 1'b1};
            default:   out_d = out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign std_is_625  = out_q.is_625;
    assign std_valid   = out_q.valid;
    assign vsync_clean = ev_valid;

    a_r5_force_625: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (std_is_625 && std_valid));

    a_r5_force_525: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (!std_is_625 && std_valid));

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> ($stable(std_is_625) && $stable(std_valid)));

    a_r2_auto_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (std_valid == $past(auto_valid)));

endmodule

// File: tb/line_std_detector_test.sv
module line_std_detector_test;
    localparam int P     = 8;
    localparam int STEP  = 2;
    localparam int HALF  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs = 1'b0, vs = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       nr_en = 1'b1;
    logic [4:0] vdel = 5'd0;
    logic       std_625, std_val, fld, vclean;

    int n_checks = 0, n_fail = 0;
    int cyc = 0, drive_cyc = 0, last_lat = -1, clean_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    line_std_detector #(
        .STEP_CYCLES (STEP),
        .HALF_LINE   (HALF)
    ) uut (
        .clk (clk), .rst_n (rst_n), .hsync_pulse (hs), .vsync_pulse (vs),
        .mode (mode), .vs_nr_en (nr_en), .vs_delay (vdel),
        .std_is_625 (std_625), .std_valid (std_val),
        .field_odd (fld), .vsync_clean (vclean)
    );

    always @(negedge clk) begin
        if (vclean) begin
            clean_cnt <= clean_cnt + 1;
            last_lat  <= cyc - drive_cyc;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One field: vs in line 0 at phase ph, optional glitch vs in line gl.
    task automatic field(int lines, int ph, int gl);
        for (int ln = 0; ln < lines; ln++) begin
            for (int c = 0; c < P; c++) begin
                @(negedge clk);
                hs = (c == 0);
                vs = (c == ph) && (ln == 0 || (gl != 0 && ln == gl));
                if (vs) drive_cyc = cyc;
            end
        end
        @(negedge clk);
        hs = 1'b0; vs = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "std", int'(std_625), 0);
        chk("R1", "valid", int'(std_val), 0);
        chk("R1", "field", int'(fld), 0);
        chk("R1", "clean", int'(vclean), 0);
    endtask

    task automatic t_auto_625();
        field(312, 1, 0);
        chk("R10", "valid after first strobe", int'(std_val), 0);
        chk("R9", "field at early phase", int'(fld), 0);
        field(312, 1, 0);
        chk("R2", "valid after one measured field", int'(std_val), 0);
        field(312, 1, 0);
        chk("R2", "valid after two agreeing fields", int'(std_val), 1);
        chk("R3", "625 decision", int'(std_625), 1);
    endtask

    task automatic t_switch_525();
        field(262, 1, 0);
        field(262, 1, 0);
        chk("R2", "single 525 field keeps 625", int'(std_625), 1);
        field(262, 1, 0);
        chk("R3", "525 decision", int'(std_625), 0);
        chk("R3", "valid stays", int'(std_val), 1);
    endtask

    task automatic t_out_of_window();
        field(290, 1, 0);
        field(290, 1, 0);
        field(290, 1, 0);
        chk("R4", "std unchanged", int'(std_625), 0);
        chk("R4", "valid unchanged", int'(std_val), 1);
    endtask

    task automatic t_noise();
        int base;
        nr_en = 1'b1;
        field(312, 1, 0);
        base = clean_cnt;
        field(312, 1, 20);
        chk("R8", "glitch dropped with filter on", clean_cnt - base, 1);
        field(312, 1, 20);
        field(312, 1, 0);
        chk("R8", "count not split by glitch", int'(std_625), 1);
        nr_en = 1'b0;
        base = clean_cnt;
        field(312, 1, 20);
        chk("R8", "glitch passes with filter off", clean_cnt - base, 2);
        nr_en = 1'b1;
        field(312, 1, 0);
    endtask

    task automatic t_phase_delay();
        field(312, 6, 0);
        chk("R9", "field at late phase", int'(fld), 1);
        chk("R7", "latency with zero delay", last_lat, 2);
        field(312, 1, 0);
        chk("R9", "field back to early", int'(fld), 0);
        vdel = 5'd2;
        field(312, 1, 0);
        chk("R7", "latency with delay 2", last_lat, 2 * STEP + 2);
        chk("R9", "delay moves phase past half line", int'(fld), 1);
        vdel = 5'd0;
    endtask

    task automatic t_modes();
        @(negedge clk) mode = 2'b10;
        @(negedge clk);
        chk("R5", "force 525 std", int'(std_625), 0);
        chk("R5", "force 525 valid", int'(std_val), 1);
        mode = 2'b01;
        @(negedge clk);
        chk("R5", "force 625 std", int'(std_625), 1);
        mode = 2'b11;
        field(262, 1, 0);
        field(262, 1, 0);
        field(262, 1, 0);
        chk("R6", "hold keeps 625", int'(std_625), 1);
        chk("R6", "hold keeps valid", int'(std_val), 1);
        mode = 2'b00;
        @(negedge clk);
        chk("R6", "auto tracked under hold", int'(std_625), 0);
    endtask

    initial begin
        t_reset();
        t_auto_625();
        t_switch_525();
        t_out_of_window();
        t_noise();
        t_phase_delay();
        t_modes();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule